// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a synthesizable model of the slave side of a small serial EEPROM on an SPI bus (clock idle low, data sampled on the rising edge). A bus master drives an active-low select, a serial clock and a data line. The block answers on its own data-out line. All three bus inputs are brought into the system clock domain through a short synchronizer chain. The bus clock must therefore run well below the system clock.

Three instructions are decoded. Write-enable arms a latch. Write sends two address bytes and then data bytes. Read sends two address bytes and then streams data out. Write data is collected in a page buffer and reaches the array only when select rises cleanly at the end of a whole byte. The array then stays busy for a fixed number of clocks. During that time the bus is not served, and the write-enable latch drops when the cycle ends. Every select edge restarts the bit framing, so a stray clock pulse cannot shift the framing of later instructions.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset `miso` and `busy` are low, the write-enable latch is clear and every array byte reads as 0x00.
- R2: Opcodes are 0x06 (write-enable), 0x02 (write) and 0x03 (read). Bits travel MSB first and are sampled on a rising `sck`. The opcode is followed by a 16-bit address, high byte first, and only its low ADDR_W bits select a byte.
- R3: The write-enable latch is set only when select rises after a frame that held exactly the 8 bits of opcode 0x06. A write that follows write-enable inside the same select frame stores nothing.
- R4: A write issued while the latch is clear leaves the array unchanged and does not raise `busy`.
- R5: Write data bytes fill a page buffer of 2^PAGE_W bytes starting at the address offset. The offset wraps inside the page, and the page-select bits of the address are kept.
- R6: A write is committed only if select rises when the bit count since the opcode is a multiple of 8 and at least one data byte was received. Otherwise the buffer is discarded and `busy` stays low.
- R7: A committed write raises `busy` within a few clocks of the select rise and holds it for exactly WRITE_CYCLES clocks. The array then holds the new bytes and the write-enable latch is cleared.
- R8: Any frame that begins while `busy` is high is ignored. `miso` stays low and a write-enable in that frame does not arm the latch.
- R9: During a read, `miso` presents the addressed byte MSB first. It changes after falling `sck` edges and the first bit is valid before the first data clock. The address advances after each byte and wraps at the top of the array.
- R10: `miso` is low whenever select is high, and raising select ends a read.
- R11: Every select assertion restarts framing at bit 7 of an opcode, so a stray `sck` pulse in an earlier frame has no lasting effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Bus select, active low |
| sck | input | 1 | Bus serial clock |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| busy | output | 1 | High while an internal write cycle runs |

## Verification
The hardest states to reach from the ports are the ones that depend on where in a frame select rises, or on a frame overlapping the write cycle. The bench therefore drives the bus bit by bit. It can stop a frame a few bits past a byte boundary, insert a single stray clock pulse, or place a write after write-enable without releasing select. The write cycle is made long enough for a whole read frame and a write-enable frame to fit inside it. This shows that both are ignored and that the latch is still clear afterwards.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_STORE = 8'h02;
  localparam logic [7:0] OP_FETCH = 8'h03;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADH,
    ST_ADL,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } frame_st_t;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_act,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam logic [2:0] IDLE_V = 3'b100;

  logic [2:0] raw;
  logic [2:0] cur;
  logic [2:0] last_q;

  assign raw = {cs_n, sck, mosi};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [2:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_V;
        else        q <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IDLE_V;
        else        q <= g_stage[g-1].q;
      end
    end
  end

  assign cur = g_stage[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_V;
    else        last_q <= cur;
  end

  assign cs_act   = ~cur[2];
  assign cs_fall  = last_q[2] & ~cur[2];
  assign cs_rise  = ~last_q[2] & cur[2];
  assign sck_rise = cur[1] & ~last_q[1] & ~cur[2];
  assign sck_fall = ~cur[1] & last_q[1] & ~cur[2];
  assign mosi_s   = cur[0];
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              busy,
  input  logic              wr_done,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              miso,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic [PAGE_W-1:0] buf_off,
  output logic [7:0]        buf_data,
  output logic              commit,
  output logic [ADDR_W-1:PAGE_W] commit_page,
  output logic              wel
);
  frame_st_t         st_q, st_d;
  logic [2:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic [7:0]        ahi_q, ahi_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [PAGE_W-1:0] off_q, off_d;
  logic [7:0]        tx_q, tx_d;
  logic              rdm_q, rdm_d;
  logic              arm_q, arm_d;
  logic              ndat_q, ndat_d;
  logic              load_q, load_d;
  logic              wel_q, wel_d;

  logic [7:0]  rx_byte;
  logic [15:0] full_addr;
  logic        byte_done;

  assign rx_byte   = {sh_q[6:0], mosi_s};
  assign full_addr = {ahi_q, rx_byte};
  assign byte_done = sck_rise && (bit_q == 3'd7);

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    ahi_d   = ahi_q;
    ptr_d   = ptr_q;
    off_d   = off_q;
    tx_d    = tx_q;
    rdm_d   = rdm_q;
    arm_d   = arm_q;
    ndat_d  = ndat_q;
    load_d  = 1'b0;
    wel_d   = wel_q;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;
    commit  = 1'b0;

    if (wr_done) wel_d = 1'b0;

    // deferred read-data fetch, one cycle after the pointer settles
    if (load_q) begin
      tx_d  = rd_data;
      ptr_d = ptr_q + 1'b1;
    end

    if (cs_fall) begin
      st_d    = busy ? ST_SKIP : ST_OPC;
      bit_d   = 3'd0;
      arm_d   = 1'b0;
      ndat_d  = 1'b0;
      buf_clr = ~busy;
    end else if (cs_rise) begin
      if (arm_q && !busy) wel_d = 1'b1;
      if (st_q == ST_WDAT && bit_q == 3'd0 && ndat_q && !busy) commit = 1'b1;
      st_d  = ST_SKIP;
      bit_d = 3'd0;
      arm_d = 1'b0;
    end else if (sck_rise) begin
      sh_d  = rx_byte;
      bit_d = bit_q + 3'd1;
      arm_d = 1'b0;
      if (byte_done) begin
        unique case (st_q)
          ST_OPC: begin
            if (rx_byte == OP_ARM) begin
              arm_d = 1'b1;
              st_d  = ST_SKIP;
            end else if (rx_byte == OP_STORE) begin
              rdm_d = 1'b0;
              st_d  = wel_q ? ST_ADH : ST_SKIP;
            end else if (rx_byte == OP_FETCH) begin
              rdm_d = 1'b1;
              st_d  = ST_ADH;
            end else begin
              st_d = ST_SKIP;
            end
          end
          ST_ADH: begin
            ahi_d = rx_byte;
            st_d  = ST_ADL;
          end
          ST_ADL: begin
            ptr_d = full_addr[ADDR_W-1:0];
            off_d = full_addr[PAGE_W-1:0];
            if (rdm_q) begin
              tx_d   = 8'h00;
              load_d = 1'b1;
              st_d   = ST_RDAT;
            end else begin
              st_d = ST_WDAT;
            end
          end
          ST_WDAT: begin
            buf_wr = 1'b1;
            off_d  = off_q + 1'b1;
            ndat_d = 1'b1;
          end
          ST_RDAT: load_d = 1'b1;
          default: ;
        endcase
      end
    end else if (sck_fall) begin
      if (st_q == ST_RDAT && bit_q != 3'd0) tx_d = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SKIP;
      bit_q  <= 3'd0;
      sh_q   <= 8'h00;
      ahi_q  <= 8'h00;
      ptr_q  <= '0;
      off_q  <= '0;
      tx_q   <= 8'h00;
      rdm_q  <= 1'b0;
      arm_q  <= 1'b0;
      ndat_q <= 1'b0;
      load_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      ahi_q  <= ahi_d;
      ptr_q  <= ptr_d;
      off_q  <= off_d;
      tx_q   <= tx_d;
      rdm_q  <= rdm_d;
      arm_q  <= arm_d;
      ndat_q <= ndat_d;
      load_q <= load_d;
      wel_q  <= wel_d;
    end
  end

  assign rd_addr     = ptr_q;
  assign buf_off     = off_q;
  assign buf_data    = rx_byte;
  assign commit_page = ptr_q[ADDR_W-1:PAGE_W];
  assign wel         = wel_q;
  assign miso        = cs_act && (st_q == ST_RDAT) && tx_q[7];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 1500
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   buf_clr,
  input  logic                   buf_wr,
  input  logic [PAGE_W-1:0]      buf_off,
  input  logic [7:0]             buf_data,
  input  logic                   commit,
  input  logic [ADDR_W-1:PAGE_W] commit_page,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [7:0]             rd_data,
  output logic                   busy,
  output logic                   wr_done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]             mem_q [DEPTH];
  logic [7:0]             pbuf_q [PAGE];
  logic [PAGE-1:0]        pval_q;
  logic                   busy_q, busy_d;
  logic [TMR_W-1:0]       tmr_q, tmr_d;
  logic [ADDR_W-1:PAGE_W] page_q, page_d;

  assign wr_done = busy_q && (tmr_q == '0);

  always_comb begin
    busy_d = busy_q;
    tmr_d  = tmr_q;
    page_d = page_q;
    if (busy_q) begin
      if (wr_done) busy_d = 1'b0;
      else         tmr_d  = tmr_q - 1'b1;
    end else if (commit) begin
      busy_d = 1'b1;
      tmr_d  = TMR_W'(WRITE_CYCLES - 1);
      page_d = commit_page;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
      page_q <= '0;
    end else begin
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
      page_q <= page_d;
    end
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic hit;
    assign hit = buf_wr && (buf_off == PAGE_W'(g));

    always_ff @(posedge clk) begin
      if (hit) pbuf_q[g] <= buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pval_q[g] <= 1'b0;
      else if (buf_clr) pval_q[g] <= 1'b0;
      else if (hit)     pval_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (wr_done) begin
      for (int j = 0; j < PAGE; j++) begin
        if (pval_q[j]) mem_q[{page_q, PAGE_W'(j)}] <= pbuf_q[j];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign busy    = busy_q;
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 1500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  logic                   cs_act, cs_fall, cs_rise;
  logic                   sck_rise, sck_fall, mosi_s;
  logic                   wr_done, wel;
  logic [7:0]             rd_data, buf_data;
  logic [ADDR_W-1:0]      rd_addr;
  logic                   buf_clr, buf_wr, commit;
  logic [PAGE_W-1:0]      buf_off;
  logic [ADDR_W-1:PAGE_W] commit_page;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .cs_act   (cs_act),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  spi_ee_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_act      (cs_act),
    .cs_fall     (cs_fall),
    .cs_rise     (cs_rise),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .mosi_s      (mosi_s),
    .busy        (busy),
    .wr_done     (wr_done),
    .rd_data     (rd_data),
    .rd_addr     (rd_addr),
    .miso        (miso),
    .buf_clr     (buf_clr),
    .buf_wr      (buf_wr),
    .buf_off     (buf_off),
    .buf_data    (buf_data),
    .commit      (commit),
    .commit_page (commit_page),
    .wel         (wel)
  );

  spi_ee_array #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .buf_clr     (buf_clr),
    .buf_wr      (buf_wr),
    .buf_off     (buf_off),
    .buf_data    (buf_data),
    .commit      (commit),
    .commit_page (commit_page),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .busy        (busy),
    .wr_done     (wr_done)
  );
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker #(
  parameter int WRITE_CYCLES = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic miso,
  input logic cs_act,
  input logic cs_rise,
  input logic wel
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 32'd1;
    else           busy_cnt <= '0;
  end

  // R10: output quiet while deselected
  p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> !miso);

  // R3: latch arms only on a select rise
  p_wel_on_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  // R6: write cycle starts only on a select rise
  p_busy_from_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));

  // R7: latch is clear once the write cycle ends
  p_wel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R7: write cycle length
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == WRITE_CYCLES);

  // R8: latch cannot arm from a frame seen during the write cycle
  p_no_arm_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));
endmodule

bind spi_eeprom_slave spi_ee_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .miso    (miso),
  .cs_act  (cs_act),
  .cs_rise (cs_rise),
  .wel     (wel)
);

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  localparam int HALF = 8;
  localparam int WCYC = 1500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] wdat [16];
  logic [7:0] rdat [16];

  always #2 clk = ~clk;

  spi_eeprom_slave #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sck   (sck),
    .mosi  (mosi),
    .miso  (miso),
    .busy  (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx);
    logic [7:0] rx;
    spi_bits(tx, 8, rx);
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic busy_count(output int n);
    n = 0;
    for (int i = 0; i < WCYC + 100; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_wren();
    cs_low();
    xfer(8'h06);
    cs_high();
  endtask

  task automatic send_write(input logic [15:0] a, input int n);
    cs_low();
    xfer(8'h02);
    xfer(a[15:8]);
    xfer(a[7:0]);
    for (int i = 0; i < n; i++) xfer(wdat[i]);
  endtask

  task automatic end_write(input int exp_cycles, input string req);
    int n;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    busy_count(n);
    chk(req, n, exp_cycles);
  endtask

  task automatic do_read(input logic [15:0] a, input int n);
    logic [7:0] rx;
    cs_low();
    xfer(8'h03);
    xfer(a[15:8]);
    xfer(a[7:0]);
    for (int i = 0; i < n; i++) begin
      spi_bits(8'h00, 8, rx);
      rdat[i] = rx;
    end
    cs_high();
  endtask

  task automatic t_reset();
    chk("R1 miso after reset", int'(miso), 0);
    chk("R1 busy after reset", int'(busy), 0);
    do_read(16'h0000, 2);
    chk("R1 array byte 0", int'(rdat[0]), 8'h00);
    chk("R1 array byte 1", int'(rdat[1]), 8'h00);
    chk("R10 miso low after read", int'(miso), 0);
  endtask

  task automatic t_no_latch();
    wdat[0] = 8'hAA;
    send_write(16'h0010, 1);
    end_write(0, "R4 no busy without latch");
    do_read(16'h0010, 1);
    chk("R4 array unchanged", int'(rdat[0]), 8'h00);
  endtask

  task automatic t_same_frame();
    cs_low();
    xfer(8'h06);
    xfer(8'h02);
    xfer(8'h00);
    xfer(8'h10);
    xfer(8'h55);
    end_write(0, "R3 write in arming frame");
    do_read(16'h0010, 1);
    chk("R3 array unchanged", int'(rdat[0]), 8'h00);
  endtask

  task automatic t_write_read();
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    do_wren();
    send_write(16'h0020, 3);
    end_write(WCYC, "R7 busy length");
    do_read(16'h0020, 4);
    chk("R9 read byte 0", int'(rdat[0]), 8'h11);
    chk("R9 read byte 1", int'(rdat[1]), 8'h22);
    chk("R9 read byte 2", int'(rdat[2]), 8'h33);
    chk("R9 read byte 3", int'(rdat[3]), 8'h00);
    do_read(16'h1221, 1);
    chk("R2 upper address bits ignored", int'(rdat[0]), 8'h22);
    // latch must be clear after the completed write
    wdat[0] = 8'h5A;
    send_write(16'h0030, 1);
    end_write(0, "R7 latch cleared after write");
  endtask

  task automatic t_busy_ignore();
    wdat[0] = 8'h77;
    do_wren();
    send_write(16'h0040, 1);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R7 busy after commit", int'(busy), 1);
    do_read(16'h0020, 1);
    chk("R8 read ignored while busy", int'(rdat[0]), 8'h00);
    do_wren();
    chk("R8 still busy", int'(busy), 1);
    wait_idle();
    do_read(16'h0040, 1);
    chk("R7 committed byte", int'(rdat[0]), 8'h77);
    wdat[0] = 8'h99;
    send_write(16'h0041, 1);
    end_write(0, "R8 arming during busy ignored");
    do_read(16'h0041, 1);
    chk("R8 array unchanged", int'(rdat[0]), 8'h00);
  endtask

  task automatic t_misaligned();
    logic [7:0] rx;
    wdat[0] = 8'hAB;
    do_wren();
    send_write(16'h0050, 1);
    spi_bits(8'hE0, 3, rx);
    end_write(0, "R6 partial byte discards");
    do_read(16'h0050, 1);
    chk("R6 array unchanged", int'(rdat[0]), 8'h00);
    do_wren();
    send_write(16'h0050, 0);
    end_write(0, "R6 no data byte discards");
  endtask

  task automatic t_page_wrap();
    wdat[0] = 8'hA1; wdat[1] = 8'hA2; wdat[2] = 8'hA3;
    do_wren();
    send_write(16'h006E, 3);
    end_write(WCYC, "R5 page write busy");
    do_read(16'h006E, 2);
    chk("R5 offset 14", int'(rdat[0]), 8'hA1);
    chk("R5 offset 15", int'(rdat[1]), 8'hA2);
    do_read(16'h0060, 1);
    chk("R5 wrapped to offset 0", int'(rdat[0]), 8'hA3);
    do_read(16'h0070, 1);
    chk("R5 next page untouched", int'(rdat[0]), 8'h00);
  endtask

  task automatic t_read_wrap();
    wdat[0] = 8'hC3;
    do_wren();
    send_write(16'h00FF, 1);
    end_write(WCYC, "R9 write top byte");
    wdat[0] = 8'h3C;
    do_wren();
    send_write(16'h0000, 1);
    end_write(WCYC, "R9 write bottom byte");
    do_read(16'h00FF, 2);
    chk("R9 top byte", int'(rdat[0]), 8'hC3);
    chk("R9 address wraps", int'(rdat[1]), 8'h3C);
  endtask

  task automatic t_resync();
    logic [7:0] rx;
    cs_low();
    spi_bits(8'h80, 1, rx);
    cs_high();
    do_read(16'h0021, 1);
    chk("R11 framing restored", int'(rdat[0]), 8'h22);
    chk("R10 miso low when deselected", int'(miso), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_no_latch();
    t_same_frame();
    t_write_read();
    t_busy_ignore();
    t_misaligned();
    t_page_wrap();
    t_read_wrap();
    t_resync();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule